// File: doc/BRIEF.md
# Interval Timer with Power-Mode Freeze

This block is a down-counting interval timer that sets an interrupt flag each time its count runs out. It then reloads itself from a modulus register. A small local register port holds the configuration. Software writes the port through byte-lane strobes and reads it back one cycle later. The timer advances one step per clock while it is enabled.

The block watches four system power-mode inputs: wait, doze, stop and debug. On every cycle it decides whether the count moves or is held. Two per-timer control bits choose whether doze or debug freezes the timer. Stop always freezes it, and wait never does. While the timer is frozen, the count and flag keep their values. Register writes made while frozen still take effect, and counting then continues from the resulting state.

Top module: `pwrgate_interval_timer`

## Requirements
- R1: After synchronous reset, every control bit and the flag are 0, the modulus and the count are all ones, and `rd_data` and `irq` are 0.
- R2: Word 0 holds control/status in bits [15:0] and the modulus in bits [31:16]. Word 1 holds the count in bits [15:0] and reads 0 above that. Control bits are: [0] enable, [1] flag, [2] interrupt enable, [3] overwrite enable, [4] debug freeze, [5] doze freeze. Other control bits read 0. Byte lane 0 writes the control bits, and lanes 2 and 3 write the modulus bytes. `rd_data` shows the state as it stood at the edge where `rd_addr` was sampled.
- R3: While enabled and not frozen, the count drops by one per clock. On the clock after it reaches 0, it reloads the modulus and sets the flag, so the period is modulus+1 clocks.
- R4: A control write that turns enable from 0 to 1 loads the count with the modulus. While enable is 0, the count holds.
- R5: Writing 1 to the flag bit clears it, and writing 0 leaves it alone. A wrap in the same cycle as a clear leaves the flag set.
- R6: `irq` equals the flag AND interrupt enable as held in the registers after each edge.
- R7: A modulus write loads the count at once when overwrite enable, as held before that write, is 1. This applies even when the timer is disabled or frozen. When overwrite enable is 0, the new modulus is used at the next reload. A load takes priority over the step of that cycle.
- R8: Writes to word 1 change nothing.
- R9: The wait input has no effect on the timer.
- R10: With doze freeze set, doze holds the count and flag. With doze freeze clear, doze has no effect.
- R11: With debug freeze set, debug holds the count and flag. Register writes made during debug take effect and remain after debug ends.
- R12: Stop holds the count and flag whatever the control bits are.
- R13: After any freeze ends, counting resumes from the held count and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wait | input | 1 | System wait mode |
| mode_doze | input | 1 | System doze mode |
| mode_stop | input | 1 | System stop mode |
| mode_debug | input | 1 | Debug halt |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Word select for writes |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Word select for reads |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are same-cycle collisions. One is a wrap that lands in the very cycle of a flag clear. Another is an enable rising together with an overwrite-enabled modulus write while a freeze input is active. The stimulus uses a modulus of 1 and issues flag clears every cycle, so wraps and clears coincide often. It then runs a long random phase that mixes writes on all lanes with the mode inputs. A behavioural model in the bench checks the read word and `irq` on every clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int B_EN    = 0;
  localparam int B_FLAG  = 1;
  localparam int B_IE    = 2;
  localparam int B_OVW   = 3;
  localparam int B_DBGF  = 4;
  localparam int B_DOZEF = 5;
  localparam int CTRL_BITS = 6;

  typedef struct packed {
    logic dozef;
    logic dbgf;
    logic ovw;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] MOD_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [2*CNT_W/8-1:0] wr_be,
  input  logic [2*CNT_W-1:0]   wr_data,
  output ctrl_t                ctrl_q,
  output ctrl_t                ctrl_d,
  output logic [CNT_W-1:0]     mod_q,
  output logic [CNT_W-1:0]     load_val,
  output logic                 load_now,
  output logic                 flag_clr
);
  localparam int BE_W = 2 * CNT_W / 8;
  localparam int HB   = BE_W / 2;

  logic             wr0, mod_wr, ctrl_wr;
  logic [CNT_W-1:0] mod_d;
  logic             unused_bits;

  assign wr0     = wr_en && !wr_addr;
  assign ctrl_wr = wr0 && wr_be[0];
  assign mod_wr  = wr0 && (|wr_be[BE_W-1:HB]);

  for (genvar j = 0; j < HB; j++) begin : g_lane
    assign mod_d[8*j +: 8] = (wr0 && wr_be[HB+j]) ? wr_data[CNT_W + 8*j +: 8]
                                                   : mod_q[8*j +: 8];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.en    = wr_data[B_EN];
      ctrl_d.ie    = wr_data[B_IE];
      ctrl_d.ovw   = wr_data[B_OVW];
      ctrl_d.dbgf  = wr_data[B_DBGF];
      ctrl_d.dozef = wr_data[B_DOZEF];
    end
  end

  assign flag_clr = ctrl_wr && wr_data[B_FLAG];
  assign load_now = (mod_wr && ctrl_q.ovw) ||
                    (ctrl_wr && wr_data[B_EN] && !ctrl_q.en);
  assign load_val = mod_d;
  assign unused_bits = ^{wr_data[CNT_W-1:CTRL_BITS], wr_be};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mod_q  <= MOD_RST;
    end else begin
      ctrl_q <= ctrl_d;
      mod_q  <= mod_d;
    end
  end

  // R8: a write to the count word leaves configuration untouched
  p_cnt_word_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> ($stable(mod_q) && $stable(ctrl_q)));
endmodule

// File: rtl/ptmr_gate.sv
module ptmr_gate
  import ptmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_q,
  input  logic  mode_wait,
  input  logic  mode_doze,
  input  logic  mode_stop,
  input  logic  mode_debug,
  output logic  advance
);
  logic freeze;
  logic unused_wait;

  assign freeze  = (mode_doze && ctrl_q.dozef) ||
                   (mode_debug && ctrl_q.dbgf) || mode_stop;
  assign advance = ctrl_q.en && !freeze;
  assign unused_wait = mode_wait;

  // R9: wait alone never stops an enabled timer
  p_wait_neutral_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_wait && !mode_doze && !mode_debug && !mode_stop && ctrl_q.en) |-> advance);
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] mod_q,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q,
  output logic             flag_d
);
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    cnt_d = count_q;
    wrap  = 1'b0;
    if (load_now) begin
      cnt_d = load_val;
    end else if (advance) begin
      if (count_q == '0) begin
        cnt_d = mod_q;
        wrap  = 1'b1;
      end else begin
        cnt_d = count_q - 1'b1;
      end
    end
  end

  assign flag_d = wrap || (flag_q && !flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= CNT_RST;
      flag_q  <= 1'b0;
    end else begin
      count_q <= cnt_d;
      flag_q  <= flag_d;
    end
  end

  // R3: one step down per enabled clock
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load_now && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  // R3: expiry reloads the modulus and raises the flag
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load_now && count_q == '0) |=> (count_q == $past(mod_q) && flag_q));
  // R13: no step and no load means the count holds
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load_now) |=> $stable(count_q));
  // R5: the flag rises only on an expiry
  p_flag_src_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(advance && !load_now && count_q == '0)) |=> !flag_q);
endmodule

// File: rtl/pwrgate_interval_timer.sv
module pwrgate_interval_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] MOD_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_wait,
  input  logic                 mode_doze,
  input  logic                 mode_stop,
  input  logic                 mode_debug,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [2*CNT_W/8-1:0] wr_be,
  input  logic [2*CNT_W-1:0]   wr_data,
  input  logic                 rd_addr,
  output logic [2*CNT_W-1:0]   rd_data,
  output logic                 irq
);
  localparam int DW = 2 * CNT_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] mod_q, load_val, count_q;
  logic             load_now, flag_clr, advance, flag_q, flag_d;
  logic [DW-1:0]    rd_mux;

  ptmr_regs #(.CNT_W(CNT_W), .MOD_RST(MOD_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .mod_q(mod_q),
    .load_val(load_val), .load_now(load_now), .flag_clr(flag_clr)
  );

  ptmr_gate u_gate (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .mode_wait(mode_wait),
    .mode_doze(mode_doze), .mode_stop(mode_stop), .mode_debug(mode_debug),
    .advance(advance)
  );

  ptmr_counter #(.CNT_W(CNT_W), .CNT_RST(MOD_RST)) u_cnt (
    .clk(clk), .rst(rst), .advance(advance), .load_now(load_now),
    .load_val(load_val), .mod_q(mod_q), .flag_clr(flag_clr),
    .count_q(count_q), .flag_q(flag_q), .flag_d(flag_d)
  );

  always_comb begin
    if (rd_addr) begin
      rd_mux = {{CNT_W{1'b0}}, count_q};
    end else begin
      rd_mux = {mod_q, {(CNT_W-CTRL_BITS){1'b0}}, ctrl_q.dozef, ctrl_q.dbgf,
                ctrl_q.ovw, ctrl_q.ie, flag_q, ctrl_q.en};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_mux;
      irq     <= flag_d && ctrl_d.ie;
    end
  end

  // R12: stop freezes the count and keeps the flag from rising
  p_stop_freeze_r12: assert property (@(posedge clk) disable iff (rst)
    (mode_stop && !load_now) |=> ($stable(count_q) && !$rose(flag_q)));
  // R6: interrupt stays low while masked
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.ie |-> !irq);
  // R6: interrupt follows the flag
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_q);
endmodule

// File: tb/pwrgate_interval_timer_tb.sv
module pwrgate_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wait = 0, mode_doze = 0, mode_stop = 0, mode_debug = 0;
  logic        wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  always #2 clk = ~clk;

  pwrgate_interval_timer u_dut (
    .clk(clk), .rst(rst), .mode_wait(mode_wait), .mode_doze(mode_doze),
    .mode_stop(mode_stop), .mode_debug(mode_debug), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    done = 0;

  // behavioural reference
  logic [15:0] m_cnt, m_mod, nm;
  logic        m_flag, m_en, m_ie, m_ovw, m_dbgf, m_dozef;
  logic        w0, cw, ld, frz, adv, st;
  logic [31:0] e_rd;
  logic        e_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 16'hFFFF; m_mod = 16'hFFFF; m_flag = 0;
      m_en = 0; m_ie = 0; m_ovw = 0; m_dbgf = 0; m_dozef = 0;
      e_rd = '0; e_irq = 0;
    end else begin
      e_rd = rd_addr ? {16'h0, m_cnt}
                     : {m_mod, 10'h0, m_dozef, m_dbgf, m_ovw, m_ie, m_flag, m_en};
      w0 = wr_en && !wr_addr;
      nm = m_mod;
      if (w0 && wr_be[2]) nm[7:0]  = wr_data[23:16];
      if (w0 && wr_be[3]) nm[15:8] = wr_data[31:24];
      cw  = w0 && wr_be[0];
      ld  = (w0 && (wr_be[2] || wr_be[3]) && m_ovw) || (cw && wr_data[0] && !m_en);
      frz = (mode_doze && m_dozef) || (mode_debug && m_dbgf) || mode_stop;
      adv = m_en && !frz;
      st  = 0;
      if (ld) m_cnt = nm;
      else if (adv) begin
        if (m_cnt == 0) begin m_cnt = m_mod; st = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (st) m_flag = 1;
      else if (cw && wr_data[1]) m_flag = 0;
      m_mod = nm;
      if (cw) begin
        m_en = wr_data[0]; m_ie = wr_data[2]; m_ovw = wr_data[3];
        m_dbgf = wr_data[4]; m_dozef = wr_data[5];
      end
      e_irq = m_flag && m_ie;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("rd_data", rd_data, e_rd);
    chk("irq", {31'h0, irq}, {31'h0, e_irq});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic a, logic [3:0] be, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    cyc();
    wr_en = 0; wr_be = '0;
  endtask

  function automatic logic [15:0] cb(bit en, bit clr, bit ie, bit ovw, bit dbgf, bit dozef);
    return {10'h0, dozef, dbgf, ovw, ie, clr, en};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog act=hung exp=done", req);
    finish_up();
  end

  initial begin
    // R1 reset state
    req = "R1";
    idle(3);
    rst = 0;
    rd_addr = 0; idle(2);
    chk("R1 word0", rd_data, 32'hFFFF_0000);
    rd_addr = 1; idle(2);
    chk("R1 count", rd_data, 32'h0000_FFFF);

    // R2 layout and byte lanes
    req = "R2"; rd_addr = 0;
    wr(0, 4'b0001, {16'h0, cb(0,0,1,0,1,1)}); idle(2);
    wr(0, 4'b1100, 32'h0005_FFFF); idle(2);
    wr(0, 4'b0100, 32'h0007_0000); idle(2);
    wr(0, 4'b0010, 32'hFFFF_FFFF); idle(2);
    chk("R2 word0", rd_data, 32'h0007_0034);
    wr(0, 4'b0001, {16'h0, cb(0,0,0,0,0,0)}); idle(2);

    // R4 enable loads, disable holds
    req = "R4"; rd_addr = 1;
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)}); idle(4);
    wr(0, 4'b0001, {16'h0, cb(0,0,1,0,0,0)}); idle(5);
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)}); idle(2);

    // R3 countdown and wrap
    req = "R3"; idle(30);

    // R5 W1C, collisions with wrap
    req = "R5";
    wr(0, 4'b1100, 32'h0001_0000); idle(4);
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)}); idle(2);
    for (int i = 0; i < 10; i++) wr(0, 4'b0001, {16'h0, cb(1,1,1,0,0,0)});
    rd_addr = 0; idle(3);

    // R6 interrupt masking
    req = "R6";
    wr(0, 4'b0001, {16'h0, cb(1,0,0,0,0,0)}); idle(4);
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)}); idle(4);

    // R7 overwrite vs deferred modulus
    req = "R7"; rd_addr = 1;
    wr(0, 4'b1100, 32'h0009_0000); idle(3);
    wr(0, 4'b0001, {16'h0, cb(1,0,1,1,0,0)});
    wr(0, 4'b1100, 32'h0020_0000); idle(3);
    wr(0, 4'b0001, {16'h0, cb(0,0,1,1,0,0)});
    wr(0, 4'b1100, 32'h0011_0000); idle(3);
    mode_stop = 1;
    wr(0, 4'b1000, 32'h0100_0000); idle(3);
    mode_stop = 0;
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)});
    wr(0, 4'b1100, 32'h0003_0000); idle(12);
    chk("R7 deferred", rd_data[31:16], 16'h0);

    // R8 count word is read-only
    req = "R8";
    wr(1, 4'b1111, 32'hDEAD_BEEF); idle(2);
    rd_addr = 0; wr(1, 4'b1111, 32'h1234_5678); idle(2); rd_addr = 1;

    // R9 wait neutral
    req = "R9"; wr(0, 4'b1100, 32'h0006_0000);
    mode_wait = 1; idle(10); mode_wait = 0; idle(2);

    // R10 doze
    req = "R10";
    mode_doze = 1; idle(5);
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,1)}); idle(8);
    mode_doze = 0; idle(6);

    // R11 debug with writes during halt
    req = "R11";
    wr(0, 4'b0001, {16'h0, cb(1,0,1,1,1,0)});
    mode_debug = 1; idle(4);
    wr(0, 4'b1100, 32'h0004_0000);
    wr(0, 4'b0001, {16'h0, cb(1,1,1,0,1,0)}); idle(4);
    mode_debug = 0; idle(10);

    // R12 stop
    req = "R12";
    wr(0, 4'b0001, {16'h0, cb(1,0,1,0,0,0)});
    mode_stop = 1; idle(8); mode_stop = 0; idle(6);

    // R13 mixed random traffic and freezes
    req = "R13";
    for (int i = 0; i < 4000; i++) begin
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_addr    = ($urandom_range(0, 5) == 0);
      wr_be      = 4'($urandom);
      wr_data    = {16'($urandom_range(0, 6)), 16'($urandom) & 16'h003F};
      rd_addr    = 1'($urandom);
      mode_wait  = 1'($urandom);
      mode_doze  = ($urandom_range(0, 3) == 0);
      mode_debug = ($urandom_range(0, 4) == 0);
      mode_stop  = ($urandom_range(0, 7) == 0);
      cyc();
    end
    wr_en = 0; mode_doze = 0; mode_debug = 0; mode_stop = 0;
    idle(4);
    finish_up();
  end
endmodule